// File: doc/BRIEF.md
# Row-serial lookup-table multiplier

This block multiplies two 4-bit unsigned operands over four clock cycles, one multiplier bit per cycle. A step counter picks one bit of the captured multiplier operand. That bit, the captured multiplicand and a 4-bit running high sum together form the address of a precomputed sum table. The 5-bit table entry gives the result of the step. Its least significant bit moves into a low-half shift register as the next product bit. Its upper four bits go back into the running-sum register, so that register holds the high nibble of the product once the last step is done.

The table is computed from the parameters at elaboration, so each shift-and-add step costs one table read and no adder logic. Outside the table, the only state is the counter, the bit-select mux and a few narrow registers. A client pulses `start` with both operands present, waits for the one-cycle `done` pulse and then reads `product`. The product stays valid until the next operation is accepted.

Top module: `rowlut_mult`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0.
- R2: When `done` is 1, `product` equals the unsigned product a_in*b_in of the operands captured at the accepted start, for all 256 operand pairs. This includes zero operands and 15*15 = 225.
- R3: An accepted `start` is sampled at clock edge E0. `done` is 1 for exactly the one cycle that follows edge E0+4, and is 0 in the cycle after that.
- R4: A `start` asserted while an operation is in progress is ignored. That operation's product and its `done` timing do not change.
- R5: `a_in` and `b_in` are sampled only at the accepted start edge. Changing them later does not change the result.
- R6: Once `done` has pulsed, `product` holds its value until the next accepted `start`.
- R7: Each step's table entry equals (selected multiplier bit ? multiplicand : 0) + running high sum, as a 5-bit value. Bit 0 is the next product bit, starting from product bit 0, and bits 4:1 become the new running sum.
- R8: A `start` asserted in the same cycle that `done` is 1 is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication using a_in and b_in |
| a_in | input | 4 | Multiplicand |
| b_in | input | 4 | Multiplier, consumed one bit per cycle from bit 0 upward |
| done | output | 1 | One-cycle pulse when product is valid |
| product | output | 8 | Unsigned product; high nibble from the running-sum register, low nibble from the shift register |

## Verification
All 256 operand pairs are run, and each result is compared with the arithmetic product. Zero operands test the paths where the select mux must gate the multiplicand off. Dense patterns such as 15*15 test carry propagation through every step into the top product bit. Operands with a single bit set show whether the counter picks multiplier bits in the right order and whether the low bits shift in at the right positions. Further runs change the operand inputs after start, pulse start in the middle of an operation, and start a new operation in the same cycle that done is high. These runs separate correct operand capture and start gating from designs that only happen to work when the inputs are held still.

// File: rtl/rowlut_pkg.sv
package rowlut_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/rowlut_step_ctrl.sv
module rowlut_step_ctrl #(
    parameter int OPW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] b_in,
    output logic           accept,
    output logic           busy,
    output logic           sel_bit,
    output logic [OPW-1:0] b_q,
    output logic           done
);
    import rowlut_pkg::*;

    localparam int CNTW = (OPW > 1) ? $clog2(OPW) : 1;
    localparam logic [CNTW-1:0] LAST_STEP = CNTW'(OPW - 1);

    typedef struct packed {
        phase_e          phase;
        logic [CNTW-1:0] cnt;
        logic [OPW-1:0]  b;
        logic            done;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = start && (st_q.phase == PH_IDLE);
        if (accept) begin
            st_d.phase = PH_RUN;
            st_d.cnt   = '0;
            st_d.b     = b_in;
        end else if (st_q.phase == PH_RUN) begin
            if (st_q.cnt == LAST_STEP) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, b: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.phase == PH_RUN);
    assign sel_bit = st_q.b[st_q.cnt];
    assign b_q     = st_q.b;
    assign done    = st_q.done;

endmodule

// File: rtl/rowlut_sum_rom.sv
module rowlut_sum_rom #(
    parameter int OPW = 4
) (
    input  logic           sel_bit,
    input  logic [OPW-1:0] mcand,
    input  logic [OPW-1:0] psum,
    output logic [OPW:0]   sum
);
    localparam int AW    = 2 * OPW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int SUMW  = OPW + 1;

    logic [SUMW-1:0] table_w [DEPTH];
    logic [AW-1:0]   addr;

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam logic [AW-1:0] ADR = AW'(k);
        assign table_w[k] = (ADR[AW-1] ? SUMW'(ADR[2*OPW-1:OPW]) : SUMW'(0))
                          + SUMW'(ADR[OPW-1:0]);
    end

    assign addr = {sel_bit, mcand, psum};
    assign sum  = table_w[addr];

endmodule

// File: rtl/rowlut_accum.sv
module rowlut_accum #(
    parameter int OPW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [OPW-1:0] a_in,
    input  logic [OPW:0]   lut_sum,
    output logic [OPW-1:0] a_q,
    output logic [OPW-1:0] psum,
    output logic [OPW-1:0] low
);
    typedef struct packed {
        logic [OPW-1:0] a;
        logic [OPW-1:0] hi;
        logic [OPW-1:0] lo;
    } acc_s;

    acc_s acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (load) begin
            acc_d.a  = a_in;
            acc_d.hi = '0;
            acc_d.lo = '0;
        end else if (step) begin
            acc_d.hi = lut_sum[OPW:1];
            acc_d.lo = {lut_sum[0], acc_q.lo[OPW-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign a_q  = acc_q.a;
    assign psum = acc_q.hi;
    assign low  = acc_q.lo;

endmodule

// File: rtl/rowlut_mult.sv
module rowlut_mult #(
    parameter int OPW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OPW-1:0]   a_in,
    input  logic [OPW-1:0]   b_in,
    output logic             done,
    output logic [2*OPW-1:0] product
);
    logic           accept;
    logic           busy;
    logic           sel_bit;
    logic [OPW-1:0] b_q;
    logic [OPW-1:0] a_q;
    logic [OPW-1:0] psum;
    logic [OPW-1:0] low;
    logic [OPW:0]   lut_sum;

    rowlut_step_ctrl #(.OPW(OPW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .b_in    (b_in),
        .accept  (accept),
        .busy    (busy),
        .sel_bit (sel_bit),
        .b_q     (b_q),
        .done    (done)
    );

    rowlut_sum_rom #(.OPW(OPW)) u_rom (
        .sel_bit (sel_bit),
        .mcand   (a_q),
        .psum    (psum),
        .sum     (lut_sum)
    );

    rowlut_accum #(.OPW(OPW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (busy),
        .a_in    (a_in),
        .lut_sum (lut_sum),
        .a_q     (a_q),
        .psum    (psum),
        .low     (low)
    );

    assign product = {psum, low};

endmodule

// File: rtl/rowlut_mult_chk.sv
module rowlut_mult_chk #(
    parameter int OPW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [2*OPW-1:0] product,
    input logic             busy,
    input logic [OPW-1:0]   a_q,
    input logic [OPW-1:0]   b_q,
    input logic             sel_bit,
    input logic [OPW-1:0]   psum,
    input logic [OPW:0]     lut_sum
);
    localparam int PW = 2 * OPW;

    a_r2_product_value: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == (PW'(a_q) * PW'(b_q))));

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(a_q) && $stable(b_q)));

    a_r6_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    a_r7_table_entry: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lut_sum == ((sel_bit ? (OPW+1)'(a_q) : (OPW+1)'(0)) + (OPW+1)'(psum))));

endmodule

bind rowlut_mult rowlut_mult_chk #(.OPW(OPW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .product (product),
    .busy    (busy),
    .a_q     (a_q),
    .b_q     (b_q),
    .sel_bit (sel_bit),
    .psum    (psum),
    .lut_sum (lut_sum)
);

// File: tb/sim_rowlut_mult.sv
`timescale 1ns/1ps
module sim_rowlut_mult;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic       done;
    logic [7:0] product;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    rowlut_mult u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .a_in    (a_in),
        .b_in    (b_in),
        .done    (done),
        .product (product)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Caller is at a negedge; drive start, return at the negedge after the accept edge.
    task automatic launch(input logic [3:0] a, input logic [3:0] b);
        start = 1'b1;
        a_in  = a;
        b_in  = b;
        @(negedge clk);
        start = 1'b0;
        a_in  = ~a;      // R5: operands change after capture
        b_in  = ~b;
    endtask

    // Returns at the negedge where done is seen; lat = negedges waited.
    task automatic await_done(output int lat);
        lat = 0;
        for (int k = 1; k <= 8; k++) begin
            if (done) break;
            @(negedge clk);
            lat = k;
        end
    endtask

    initial begin
        int lat;
        logic [7:0] held;

        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done at reset", int'(done), 0);
        check(product == 8'd0, "R1 product at reset", int'(product), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R5: exhaustive sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                launch(4'(a), 4'(b));
                check(done == 1'b0, "R3 done early", int'(done), 0);
                await_done(lat);
                check(lat == 4, "R3 done latency", lat, 4);
                check(int'(product) == a * b, "R2 product", int'(product), a * b);
                @(negedge clk);
                check(done == 1'b0, "R3 done width", int'(done), 0);
            end
        end

        // R6: product holds while idle with operand inputs wiggling
        launch(4'd13, 4'd11);
        await_done(lat);
        held = product;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            a_in = 4'(k * 3);
            b_in = 4'(k * 5 + 1);
        end
        check(product == held, "R6 product hold", int'(product), int'(held));
        check(int'(held) == 143, "R2 product 13*11", int'(held), 143);

        // R4: start pulsed mid-operation is ignored
        launch(4'd3, 4'd5);
        start = 1'b1;
        a_in  = 4'd15;
        b_in  = 4'd15;
        @(negedge clk);
        start = 1'b0;
        await_done(lat);
        check(lat == 3, "R4 done timing unchanged", lat, 3);
        check(int'(product) == 15, "R4 product unchanged", int'(product), 15);
        @(negedge clk);
        check(done == 1'b0, "R4 no extra done", int'(done), 0);

        // R8: back-to-back start on the done cycle
        launch(4'd9, 4'd7);
        await_done(lat);
        check(int'(product) == 63, "R8 first product", int'(product), 63);
        launch(4'd15, 4'd15);
        await_done(lat);
        check(lat == 4, "R8 back-to-back latency", lat, 4);
        check(int'(product) == 225, "R8 second product", int'(product), 225);

        // R7: single-bit multipliers exercise bit order and shift positions
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            launch(4'd9, 4'(1 << i));
            await_done(lat);
            check(int'(product) == (9 << i), "R7 bit order", int'(product), 9 << i);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule